// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Model

This block is a synthesizable stand-in for a synchronous static RAM in which a write and a read take the same number of clock edges from command to data. Because of that match, a bus master can issue reads and writes in any order on consecutive cycles and never has to insert an idle cycle when the data bus changes direction. The storage is a small internal array of words. Each word is split into byte lanes, and each lane has its own write strobe.

On every rising clock edge, and only while the clock enable is low, the block samples a command. The command is formed from the address, three chip-select inputs, a load strobe, a write strobe and the per-lane write strobes. A static input picks one of two timings. In pipelined timing, read data appears one enabled edge after the command and write data is taken two enabled edges after it. In flow-through timing, read data appears right after the command edge and write data is taken on the next enabled edge.

A read that targets a word whose write is still waiting for its late data returns the newest bytes. The data bus is split into an input and an output. The output carries a drive flag that stands in for a three-state enable. An asynchronous output enable gates the drive flag.

Top module: `zt_sram`

## Requirements
- R1: While `clk_en_n` is high, a clock edge has no effect. No command is taken, pending writes and read data hold, and `din` is ignored. Pipeline timing counts enabled edges only.
- R2: The block is selected only when `chip_sel_a` is 0, `chip_sel_b` is 1 and `chip_sel_c` is 0 (the default polarities). Any other combination is a deselect: nothing is read, nothing is written, and the drive flag stays low in that command's output slot.
- R3: An access starts only when `load_n` is 0 on a selected, enabled edge. With `load_n` at 1, no access starts, the array is unchanged and the drive flag stays low.
- R4: A started access is a read when `wr_n` is 1 and a write when `wr_n` is 0. A write cycle never raises the drive flag, and reads and writes may alternate on back-to-back edges.
- R5: `lane_wr_n[i]` low writes lane i, which is bits 8i+7 down to 8i of the word, and leaves the other lanes unchanged. A write with all four strobes high changes nothing.
- R6: With `flow_thru` = 0, read data is on `dout` with `dout_drive` high after the second enabled edge, counting the command edge as the first.
- R7: With `flow_thru` = 0, the data for a write is taken from `din` on the third enabled edge, counting the command edge as the first.
- R8: With `flow_thru` = 1, read data is on `dout` with `dout_drive` high right after the command edge.
- R9: With `flow_thru` = 1, the data for a write is taken from `din` on the second enabled edge.
- R10: `out_en_n` acts without a clock. While it is high, `dout_drive` is 0 and `dout` is 0.
- R11: A read returns every byte written by earlier write commands, including writes whose data has not yet reached the array. Several pending writes to the same word merge lane by lane, with the newest one winning.
- R12: A synchronous reset (`rst` high on an edge) cancels pending reads and writes and leaves `dout_drive` low until the first read after reset reaches its output slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| flow_thru | input | 1 | Static timing select: 1 flow-through, 0 pipelined |
| clk_en_n | input | 1 | Clock enable, active low |
| chip_sel_a | input | 1 | Chip select, active low by default |
| chip_sel_b | input | 1 | Chip select, active high by default |
| chip_sel_c | input | 1 | Chip select, active low by default |
| load_n | input | 1 | Low to start a new single access |
| wr_n | input | 1 | Low for write, high for read |
| lane_wr_n | input | LANES | Per-lane write strobes, active low |
| addr | input | ADDR_W | Word address |
| din | input | LANES*LANE_W | Late write data |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| dout | output | LANES*LANE_W | Read data; zero when not driving |
| dout_drive | output | 1 | High when `dout` carries valid read data |

## Verification
The main function is exercised in both timings with several patterns. Streams of only writes and only reads check the basic latencies on their own. Strict read/write alternation shows that no dead cycle is needed. A read placed one and two edges behind a write to the same word separates the two bypass paths, and two partial writes followed by a read show whether the lane merge keeps the newest bytes. Stalls between a write command and its data, with junk on `din` and a write command held on the pins, show whether the edge count skips disabled edges. Deselects on each chip select, a held load strobe and an all-strobes-off write show that nothing reaches the array, and this is read back afterwards.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

endpackage

// File: rtl/zt_cmd_decode.sv
module zt_cmd_decode
  import zt_sram_pkg::*;
#(
  parameter int LANES   = 4,
  parameter bit SEL_A_ON = 1'b0,
  parameter bit SEL_B_ON = 1'b1,
  parameter bit SEL_C_ON = 1'b0
) (
  input  logic             sel_a,
  input  logic             sel_b,
  input  logic             sel_c,
  input  logic             load_n,
  input  logic             wr_n,
  input  logic [LANES-1:0] lane_wr_n,
  output op_e              op,
  output logic [LANES-1:0] lane_mask
);

  logic chip_on;

  always_comb begin
    chip_on   = (sel_a == SEL_A_ON) && (sel_b == SEL_B_ON) && (sel_c == SEL_C_ON);
    lane_mask = ~lane_wr_n;
    op        = OP_NONE;
    if (chip_on && !load_n) begin
      if (wr_n)
        op = OP_READ;
      else if (|lane_mask)
        op = OP_WRITE;
    end
  end

endmodule

// File: rtl/zt_lane_merge.sv
module zt_lane_merge #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic [LANES*LANE_W-1:0] base,
  input  logic [LANES*LANE_W-1:0] patch,
  input  logic [LANES-1:0]        mask,
  output logic [LANES*LANE_W-1:0] merged
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*LANE_W +: LANE_W] = mask[g] ? patch[g*LANE_W +: LANE_W]
                                                : base[g*LANE_W +: LANE_W];
  end

endmodule

// File: rtl/zt_store.sv
module zt_store #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        wr_mask,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // One write port with lane strobes and one registered read port
  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int i = 0; i < LANES; i++) begin
        if (wr_mask[i])
          mem[wr_addr][i*LANE_W +: LANE_W] <= wr_data[i*LANE_W +: LANE_W];
      end
    end
    if (rd_en)
      rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int LANES    = 4,
  parameter int LANE_W   = 8,
  parameter bit SEL_A_ON = 1'b0,
  parameter bit SEL_B_ON = 1'b1,
  parameter bit SEL_C_ON = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    flow_thru,
  input  logic                    clk_en_n,
  input  logic                    chip_sel_a,
  input  logic                    chip_sel_b,
  input  logic                    chip_sel_c,
  input  logic                    load_n,
  input  logic                    wr_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] din,
  input  logic                    out_en_n,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_drive
);

  localparam int DATA_W = LANES * LANE_W;

  logic             adv;
  op_e              op;
  logic [LANES-1:0] lane_mask;

  assign adv = !clk_en_n;

  zt_cmd_decode #(
    .LANES(LANES), .SEL_A_ON(SEL_A_ON), .SEL_B_ON(SEL_B_ON), .SEL_C_ON(SEL_C_ON)
  ) u_dec (
    .sel_a(chip_sel_a), .sel_b(chip_sel_b), .sel_c(chip_sel_c),
    .load_n(load_n), .wr_n(wr_n), .lane_wr_n(lane_wr_n),
    .op(op), .lane_mask(lane_mask)
  );

  // Write commands waiting for late data: w1 one enabled edge old, w2 two
  logic              w1_v, w2_v;
  logic [ADDR_W-1:0] w1_a, w2_a;
  logic [LANES-1:0]  w1_m, w2_m;

  always_ff @(posedge clk) begin
    if (rst) begin
      w1_v <= 1'b0;
      w2_v <= 1'b0;
      w1_a <= '0;
      w2_a <= '0;
      w1_m <= '0;
      w2_m <= '0;
    end else if (adv) begin
      w1_v <= (op == OP_WRITE);
      w1_a <= addr;
      w1_m <= lane_mask;
      w2_v <= w1_v;
      w2_a <= w1_a;
      w2_m <= w1_m;
    end
  end

  // The write whose data is on din at this edge
  logic              land_v;
  logic [ADDR_W-1:0] land_a;
  logic [LANES-1:0]  land_m;

  assign land_v = flow_thru ? w1_v : w2_v;
  assign land_a = flow_thru ? w1_a : w2_a;
  assign land_m = flow_thru ? w1_m : w2_m;

  logic [DATA_W-1:0] arr_q;

  zt_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk    (clk),
    .wr_en  (adv && land_v),
    .wr_addr(land_a),
    .wr_mask(land_m),
    .wr_data(din),
    .rd_en  (adv && (op == OP_READ)),
    .rd_addr(addr),
    .rd_data(arr_q)
  );

  // Stage A: read registered; patch holds the write landing on the same edge
  logic              a_v;
  logic [ADDR_W-1:0] a_addr;
  logic [LANES-1:0]  pa_mask;
  logic [DATA_W-1:0] pa_data;
  logic [DATA_W-1:0] a_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_v     <= 1'b0;
      a_addr  <= '0;
      pa_mask <= '0;
      pa_data <= '0;
    end else if (adv) begin
      a_v     <= (op == OP_READ);
      a_addr  <= addr;
      pa_mask <= (land_v && (land_a == addr)) ? land_m : '0;
      pa_data <= din;
    end
  end

  zt_lane_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_merge_a (
    .base(arr_q), .patch(pa_data), .mask(pa_mask), .merged(a_word)
  );

  // Stage B (pipelined timing): fold in the write landing one edge later
  logic [LANES-1:0]  pb_mask;
  logic [DATA_W-1:0] b_next;
  logic              b_v;
  logic [DATA_W-1:0] b_word;

  assign pb_mask = (land_v && (land_a == a_addr)) ? land_m : '0;

  zt_lane_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_merge_b (
    .base(a_word), .patch(din), .mask(pb_mask), .merged(b_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      b_v    <= 1'b0;
      b_word <= '0;
    end else if (adv) begin
      b_v    <= a_v;
      b_word <= b_next;
    end
  end

  // Output select and asynchronous output enable
  logic              sel_v;
  logic [DATA_W-1:0] sel_w;

  assign sel_v      = flow_thru ? a_v : b_v;
  assign sel_w      = flow_thru ? a_word : b_word;
  assign dout_drive = sel_v && !out_en_n;
  assign dout       = dout_drive ? sel_w : '0;

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
  parameter int DATA_W   = 32,
  parameter bit SEL_A_ON = 1'b0,
  parameter bit SEL_B_ON = 1'b1,
  parameter bit SEL_C_ON = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              flow_thru,
  input logic              clk_en_n,
  input logic              chip_sel_a,
  input logic              chip_sel_b,
  input logic              chip_sel_c,
  input logic              load_n,
  input logic              wr_n,
  input logic              out_en_n,
  input logic [DATA_W-1:0] dout,
  input logic              dout_drive
);

  logic picked;
  assign picked = (chip_sel_a == SEL_A_ON) && (chip_sel_b == SEL_B_ON) &&
                  (chip_sel_c == SEL_C_ON);

  assert_stall_hold_R1: assert property (@(posedge clk) disable iff (rst)
    clk_en_n |=> (!$stable(out_en_n) || ($stable(dout_drive) && $stable(dout))))
    else $error("stalled edge changed outputs");

  assert_deselect_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (flow_thru && !clk_en_n && !picked) |=> !dout_drive)
    else $error("deselect drove the bus");

  assert_noload_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (flow_thru && !clk_en_n && picked && load_n) |=> !dout_drive)
    else $error("unloaded cycle drove the bus");

  assert_write_quiet_flow_R4: assert property (@(posedge clk) disable iff (rst)
    (flow_thru && !clk_en_n && picked && !load_n && !wr_n) |=> !dout_drive)
    else $error("write drove the bus (flow)");

  assert_write_quiet_pipe_R4: assert property (@(posedge clk) disable iff (rst)
    (!flow_thru && !clk_en_n && picked && !load_n && !wr_n) ##1 !clk_en_n
      |=> !dout_drive)
    else $error("write drove the bus (pipelined)");

  assert_pipe_read_slot_R6: assert property (@(posedge clk) disable iff (rst)
    (!flow_thru && !clk_en_n && picked && !load_n && wr_n) ##1 !clk_en_n
      |=> (out_en_n || dout_drive))
    else $error("pipelined read missing");

  assert_flow_read_slot_R8: assert property (@(posedge clk) disable iff (rst)
    (flow_thru && !clk_en_n && picked && !load_n && wr_n) |=> (out_en_n || dout_drive))
    else $error("flow-through read missing");

  assert_oe_gate_R10: assert property (@(posedge clk) disable iff (rst)
    out_en_n |-> (!dout_drive && (dout == '0)))
    else $error("output enable ignored");

endmodule

bind zt_sram zt_sram_chk #(
  .DATA_W(LANES*LANE_W), .SEL_A_ON(SEL_A_ON), .SEL_B_ON(SEL_B_ON), .SEL_C_ON(SEL_C_ON)
) u_chk (
  .clk(clk), .rst(rst), .flow_thru(flow_thru), .clk_en_n(clk_en_n),
  .chip_sel_a(chip_sel_a), .chip_sel_b(chip_sel_b), .chip_sel_c(chip_sel_c),
  .load_n(load_n), .wr_n(wr_n), .out_en_n(out_en_n),
  .dout(dout), .dout_drive(dout_drive)
);

// File: tb/sim_zt_sram.sv
module sim_zt_sram;

  localparam int CLK_NS = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flow_thru = 1'b0;
  logic        clk_en_n = 1'b1;
  logic        chip_sel_a = 1'b1, chip_sel_b = 1'b1, chip_sel_c = 1'b0;
  logic        load_n = 1'b1, wr_n = 1'b1;
  logic [3:0]  lane_wr_n = 4'hF;
  logic [5:0]  addr = '0;
  logic [31:0] din = '0;
  logic        out_en_n = 1'b0;
  logic [31:0] dout;
  logic        dout_drive;

  always #(CLK_NS/2) clk = ~clk;

  zt_sram u0 (
    .clk(clk), .rst(rst), .flow_thru(flow_thru), .clk_en_n(clk_en_n),
    .chip_sel_a(chip_sel_a), .chip_sel_b(chip_sel_b), .chip_sel_c(chip_sel_c),
    .load_n(load_n), .wr_n(wr_n), .lane_wr_n(lane_wr_n), .addr(addr),
    .din(din), .out_en_n(out_en_n), .dout(dout), .dout_drive(dout_drive)
  );

  typedef struct {
    int          due;
    bit          v;
    logic [31:0] d;
    string       tag;
  } item_t;

  item_t       sbq[$];
  int          n_chk = 0, n_fail = 0;
  int          n_edge = 0;
  bit          done = 0;
  logic [31:0] sched [4];
  logic [31:0] ref_mem [64];

  task automatic chk(input bit ok, input string tag, input logic [32:0] act, input logic [32:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual drive=%0b data=%h expected drive=%0b data=%h",
               tag, act[32], act[31:0], exp[32], exp[31:0]);
    end
  endtask

  // Driver: one call per clock; reference updated at command time (R11)
  task automatic step(input logic ck_n, input logic sa, input logic sb, input logic sc,
                      input logic ld_n, input logic w_n, input logic [3:0] bwn,
                      input logic [5:0] a, input logic [31:0] wd, input logic oen,
                      input string tag);
    item_t it;
    bit    chosen;
    @(negedge clk);
    clk_en_n = ck_n; chip_sel_a = sa; chip_sel_b = sb; chip_sel_c = sc;
    load_n = ld_n; wr_n = w_n; lane_wr_n = bwn; addr = a; out_en_n = oen;
    if (ck_n) begin
      din = 32'hDEAD_BEEF;
    end else begin
      n_edge++;
      din = sched[n_edge % 4];
      sched[n_edge % 4] = 32'hBADC_0FFE;
      chosen = !sa && sb && !sc && !ld_n;
      it.due = n_edge + (flow_thru ? 0 : 1);
      it.v   = chosen && w_n;
      it.d   = ref_mem[a];
      it.tag = tag;
      if (chosen && !w_n) begin
        for (int i = 0; i < 4; i++)
          if (!bwn[i]) ref_mem[a][i*8 +: 8] = wd[i*8 +: 8];
        sched[(n_edge + (flow_thru ? 1 : 2)) % 4] = wd;
      end
      sbq.push_back(it);
    end
  endtask

  task automatic rd(input logic [5:0] a, input string tag);
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, a, 32'h0, 1'b0, tag);
  endtask
  task automatic wr(input logic [5:0] a, input logic [3:0] bwn, input logic [31:0] wd, input string tag);
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, bwn, a, wd, 1'b0, tag);
  endtask
  task automatic idle(input string tag);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 6'd0, 32'h0, 1'b0, tag);
  endtask
  task automatic stall(input logic [5:0] a);
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, a, 32'h0, 1'b0, "R1");
  endtask

  task automatic do_reset(input bit fm);
    @(negedge clk);
    rst = 1'b1; clk_en_n = 1'b1; chip_sel_a = 1'b1; load_n = 1'b1; out_en_n = 1'b0;
    flow_thru = fm;
    repeat (3) @(negedge clk);
    sbq.delete();
    n_edge = 0;
    rst = 1'b0;
  endtask

  // Monitor: pops the expected item due on each enabled edge
  initial begin
    int          m = 0;
    logic        s_rst, s_cke, last_oe = 1'b0, exp_dr;
    logic [31:0] exp_d, last_d = '0;
    logic        last_dr = 1'b0;
    string       tag;
    forever begin
      @(posedge clk);
      s_rst = rst; s_cke = clk_en_n;
      #2;
      if (s_rst) begin
        m = 0;
        last_dr = 1'b0; last_d = '0; last_oe = out_en_n;
      end else if (!s_cke) begin
        m++;
        exp_dr = 1'b0; exp_d = '0; tag = "R12";
        if (sbq.size() > 0 && sbq[0].due == m) begin
          item_t it;
          it = sbq.pop_front();
          exp_dr = it.v && !out_en_n;
          exp_d  = exp_dr ? it.d : 32'h0;
          tag    = it.tag;
        end
        chk((dout_drive === exp_dr) && (dout === exp_d), tag,
            {dout_drive, dout}, {exp_dr, exp_d});
        last_dr = dout_drive; last_d = dout; last_oe = out_en_n;
      end else begin
        if (out_en_n === last_oe)
          chk((dout_drive === last_dr) && (dout === last_d), "R1 stall hold",
              {dout_drive, dout}, {last_dr, last_d});
        last_dr = dout_drive; last_d = dout; last_oe = out_en_n;
      end
    end
  end

  task automatic oe_pulse(input logic [5:0] a);
    #1 out_en_n = 1'b1;
    #1 chk((dout_drive === 1'b0) && (dout === 32'h0), "R10 oe high",
           {dout_drive, dout}, {1'b0, 32'h0});
    out_en_n = 1'b0;
    #1 chk((dout_drive === 1'b1) && (dout === ref_mem[a]), "R10 oe low",
           {dout_drive, dout}, {1'b1, ref_mem[a]});
  endtask

  task automatic suite(input bit fm);
    string tr, tw;
    tr = fm ? "R8" : "R6";
    tw = fm ? "R9" : "R7";
    do_reset(fm);
    idle("R12"); idle("R12");
    for (int a = 0; a < 32; a++) wr(6'(a), 4'h0, 32'hA500_0000 ^ (a * 32'h0101_0101) ^ {31'd0, fm}, tw);
    for (int a = 0; a < 8; a++) rd(6'(a), tr);
    // strict alternation and bypass at both distances
    wr(6'd10, 4'h0, 32'h1111_2222, "R4"); rd(6'd3, "R4");
    wr(6'd11, 4'h0, 32'h3333_4444, "R4"); rd(6'd10, "R11"); rd(6'd11, "R11");
    wr(6'd12, 4'b1110, 32'h0000_00C1, "R11"); wr(6'd12, 4'b1101, 32'h0000_D200, "R11");
    rd(6'd12, "R11");
    // lane strobes
    wr(6'd4, 4'b1010, 32'hF0E0_D0C0, "R5"); rd(6'd4, "R5");
    wr(6'd5, 4'b1111, 32'hFFFF_FFFF, "R5"); rd(6'd5, "R5"); idle("R5"); rd(6'd5, "R5");
    // deselects and load held
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 6'd1, 32'h0, 1'b0, "R2");
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'hF, 6'd1, 32'h0, 1'b0, "R2");
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'hF, 6'd1, 32'h0, 1'b0, "R2");
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 6'd6, 32'h7777_7777, 1'b0, "R2");
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 6'd1, 32'h0, 1'b0, "R3");
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 6'd7, 32'h8888_8888, 1'b0, "R3");
    idle("R2"); idle("R2"); rd(6'd6, "R2"); rd(6'd7, "R3");
    // stalls
    rd(6'd1, "R1"); stall(6'd21); stall(6'd21); stall(6'd21); idle("R1"); rd(6'd21, "R1");
    wr(6'd20, 4'h0, 32'h2020_ABCD, "R1"); stall(6'd20); stall(6'd20); idle("R1"); idle("R1");
    rd(6'd20, "R1");
    // output enable held high through a read slot, then a mid-cycle pulse
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 6'd2, 32'h0, 1'b1, "R10");
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 6'd0, 32'h0, 1'b1, "R10");
    rd(6'd2, "R10");
    repeat (fm ? 1 : 2) idle("R10");
    oe_pulse(6'd2);
    repeat (4) idle("R12");
  endtask

  initial begin
    for (int i = 0; i < 4; i++) sched[i] = 32'hBADC_0FFE;
    for (int i = 0; i < 64; i++) ref_mem[i] = 32'h0;
    suite(1'b0);
    suite(1'b1);
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired (R1..all) actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule